// File: doc/BRIEF.md
# Touch Converter Serial Command Sequencer

This block is the digital front end of a serial touch-screen converter. It runs on a fast system clock and watches a slower serial bit clock, a serial data input and an active-low select line. While selected, it looks for a start bit on the data line and then shifts in a seven-bit command. The command picks the input channel, the result length, the reference style and the power behaviour. From this the block drives the channel select, the sample/hold control, the touch-panel driver enable and a busy flag, and it shifts the converted value out MSB first. A parallel sample input stands in for the analog converter. The block also keeps the power state that the last command asked for: converter power, reference power, pen-interrupt gating and the idle Y-minus switch.

The serial inputs pass through a parameterised synchroniser. Each rising bit-clock edge that reaches the system clock domain counts as one bit period. Command reception and result shifting are separate engines, so a new command can be clocked in while the previous result is still going out.

Top module: `touch_adc_seq`

## Requirements
- R1: While no command is being received and the lock-out window is over, a 0 on `din` at a bit-clock rise is ignored. The first rise with `din` = 1 is the start bit. A 1 that arrives within the first N+2 rises after an accepted start bit never starts a command.
- R2: The seven rises after the start bit carry, MSB first: channel code C[2:0], resolution bit L, reference bit S, then power code P[1:0]. `mux_sel` shows C from the rise that carries C[0] onward.
- R3: `sh_track` is 1 (tracking) after the rise that carries C[0] and stays 1 up to the rise that carries P[0]. At all other times it is 0 (hold).
- R4: `busy` is 1 for exactly the one bit period that follows the rise carrying P[0].
- R5: On the N rises after the busy period, `dout` presents the result MSB first. With L = 0, N = 12 and the result is `conv_sample[11:0]`. With L = 1, N = 8 and the result is `conv_sample[11:4]`. The sample is taken at the rise that carries P[0].
- R6: For the three bit periods after the last result bit, `dout` is 0.
- R7: `ref_diff` is 1 only when S = 0 and C is one of the touch codes 001, 011, 100 or 101. Any other channel always uses single-ended mode.
- R8: `drv_en` is 1 while tracking on a touch channel. From the busy period on it stays 1 only when `ref_diff` is 1, covering the busy period, the N result periods and one extra period. In single-ended mode it is 0 from the busy period on.
- R9: The next start bit is accepted on the (N+3)-th rise after the previous start bit (15 for 12-bit, 11 for 8-bit). A new command can therefore overlap the previous result without disturbing it.
- R10: `adc_on` is 1 when P[0] = 1, or while a command or conversion is in progress. `penirq_n` is low only when `pen_touch` is 1 and P[0] = 0.
- R11: `ref_on` takes P[1] of a command at the moment `busy` rises. It keeps that value until the next command.
- R12: `yneg_on` is 1 when P = 00 and the block is neither tracking nor converting or shifting.
- R13: `cs_n` high sets `dout_oe` to 0, aborts any command or result in progress and clears the bit counters. The power state is kept.
- R14: After reset: `busy`, `sh_track`, `ref_on`, `adc_on` and `dout_oe` are 0, `mux_sel` is 000, `yneg_on` is 1 and the pen interrupt is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Serial bit clock, sampled in the `clk` domain |
| cs_n | input | 1 | Active-low select; high aborts the frame |
| din | input | 1 | Serial command data |
| conv_sample | input | RES_W | Converted value standing in for the analog converter |
| pen_touch | input | 1 | Pen-contact indication |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |
| busy | output | 1 | Conversion-start flag, one bit period |
| mux_sel | output | 3 | Selected input channel |
| sh_track | output | 1 | Sample/hold: 1 track, 0 hold |
| drv_en | output | 1 | Touch-panel driver enable |
| ref_diff | output | 1 | 1 = ratiometric reference for the current conversion |
| ref_on | output | 1 | Internal reference power |
| adc_on | output | 1 | Converter power |
| penirq_n | output | 1 | Active-low pen interrupt |
| yneg_on | output | 1 | Y-minus switch closed while powered down |

## Verification
The in-line assertions check on every cycle that:
- `busy` follows a completed command for a single period;
- tracking and `busy` never overlap;
- single-ended conversions never hold the drivers on while busy;
- a deselect empties the output engine;
- the command counter stays inside its lock-out range.

Only the bench scenarios can show:
- the serial values themselves and the MSB-first order of 12-bit and 8-bit results;
- the zero padding;
- start bits being ignored inside the lock-out window;
- the exact rise on which an overlapped command is accepted;
- the power-code decoding after each command.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

   typedef struct packed {
      logic [2:0] chan;
      logic       low_res;
      logic       se_ref;
      logic [1:0] pwr;
   } tsq_cmd_t;

   function automatic logic chan_is_touch(input logic [2:0] ch);
      return (ch == 3'b001) || (ch == 3'b011) || (ch == 3'b100) || (ch == 3'b101);
   endfunction

endpackage

// File: rtl/tsq_sync.sv
module tsq_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      assert (STAGES >= 1 && STAGES <= 3) else $error("tsq_sync: STAGES out of range");
   end

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= RST_VAL;
            else        r_q <= d_i;
         end
         assign q_o = r_q;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= {STAGES{RST_VAL}};
            else        r_q <= {r_q[STAGES-2:0], d_i};
         end
         assign q_o = r_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tsq_cmd_rx.sv
module tsq_cmd_rx
   import tsq_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int LOW_W = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick_i,
   input  logic     abort_i,
   input  logic     din_i,
   output logic     done_o,
   output tsq_cmd_t word_o,
   output logic [2:0] chan_o,
   output logic     track_o
);
   localparam int CPOS_W = $clog2(RES_W + 3);
   localparam logic [CPOS_W-1:0] P_ONE    = CPOS_W'(1);
   localparam logic [CPOS_W-1:0] P_CH_END = CPOS_W'(3);
   localparam logic [CPOS_W-1:0] P_TRK    = CPOS_W'(4);
   localparam logic [CPOS_W-1:0] P_LAST   = CPOS_W'(7);
   localparam logic [CPOS_W-1:0] HOLD_HI  = CPOS_W'(RES_W + 2);
   localparam logic [CPOS_W-1:0] HOLD_LO  = CPOS_W'(LOW_W + 2);

   logic [CPOS_W-1:0] pos_q;
   logic [5:0]        sh_q;
   logic [2:0]        chan_q;
   logic              low_q;
   logic [CPOS_W-1:0] hold_end;

   assign hold_end = low_q ? HOLD_LO : HOLD_HI;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         sh_q   <= '0;
         chan_q <= '0;
         low_q  <= 1'b0;
      end else if (abort_i) begin
         pos_q <= '0;
         sh_q  <= '0;
      end else if (tick_i) begin
         if (pos_q == '0) begin
            if (din_i) pos_q <= P_ONE;
         end else if (pos_q == hold_end) begin
            pos_q <= '0;
         end else begin
            pos_q <= pos_q + P_ONE;
         end
         if (pos_q != '0 && pos_q < P_LAST) sh_q <= {sh_q[4:0], din_i};
         if (pos_q == P_CH_END) chan_q <= {sh_q[1:0], din_i};
         if (pos_q == P_LAST)   low_q  <= sh_q[2];
      end
   end

   assign done_o  = tick_i && !abort_i && (pos_q == P_LAST);
   assign word_o  = tsq_cmd_t'({sh_q, din_i});
   assign chan_o  = chan_q;
   assign track_o = (pos_q >= P_TRK) && (pos_q <= P_LAST);

   AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= HOLD_HI);                                             // R9
   AST_TRACK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(track_o) |-> $past(tick_i));                             // R3
endmodule

// File: rtl/tsq_out_seq.sv
module tsq_out_seq #(
   parameter int RES_W = 12,
   parameter int LOW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             abort_i,
   input  logic             load_i,
   input  logic             load_low_i,
   input  logic             load_diff_i,
   input  logic [RES_W-1:0] sample_i,
   output logic             dout_o,
   output logic             busy_o,
   output logic             drv_o,
   output logic             active_o,
   output logic             diff_o
);
   localparam int OPOS_W = $clog2(RES_W + 5);
   localparam int PAD_W  = RES_W - LOW_W;
   localparam logic [OPOS_W-1:0] O_ONE = OPOS_W'(1);
   localparam logic [OPOS_W-1:0] O_TWO = OPOS_W'(2);
   localparam logic [OPOS_W-1:0] N_HI  = OPOS_W'(RES_W);
   localparam logic [OPOS_W-1:0] N_LO  = OPOS_W'(LOW_W);
   localparam logic [OPOS_W-1:0] PAD_N = OPOS_W'(4);

   logic [OPOS_W-1:0] opos_q;
   logic [RES_W-1:0]  sreg_q;
   logic              low_q;
   logic              diff_q;
   logic [OPOS_W-1:0] nb;
   logic              in_data;
   logic [RES_W-1:0]  aligned;

   assign nb      = low_q ? N_LO : N_HI;
   assign in_data = (opos_q >= O_TWO) && (opos_q <= nb + O_ONE);
   assign aligned = load_low_i ? {sample_i[RES_W-1 -: LOW_W], {PAD_W{1'b0}}} : sample_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opos_q <= '0;
         sreg_q <= '0;
         low_q  <= 1'b0;
         diff_q <= 1'b0;
      end else if (abort_i) begin
         opos_q <= '0;
      end else if (tick_i) begin
         if (load_i) begin
            opos_q <= O_ONE;
            sreg_q <= aligned;
            low_q  <= load_low_i;
            diff_q <= load_diff_i;
         end else if (opos_q != '0) begin
            opos_q <= (opos_q == nb + PAD_N) ? '0 : opos_q + O_ONE;
            if (in_data) sreg_q <= {sreg_q[RES_W-2:0], 1'b0};
         end
      end
   end

   assign dout_o   = in_data ? sreg_q[RES_W-1] : 1'b0;
   assign busy_o   = (opos_q == O_ONE);
   assign drv_o    = diff_q && (opos_q >= O_ONE) && (opos_q <= nb + O_TWO);
   assign active_o = (opos_q != '0);
   assign diff_o   = diff_q;

   AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && load_i && !abort_i) |=> busy_o);                    // R4
   AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && tick_i && !abort_i) |=> !busy_o);                   // R4
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !active_o);                                        // R13
endmodule

// File: rtl/touch_adc_seq.sv
module touch_adc_seq
   import tsq_pkg::*;
#(
   parameter int RES_W       = 12,
   parameter int LOW_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dclk,
   input  logic             cs_n,
   input  logic             din,
   input  logic [RES_W-1:0] conv_sample,
   input  logic             pen_touch,
   output logic             dout,
   output logic             dout_oe,
   output logic             busy,
   output logic [2:0]       mux_sel,
   output logic             sh_track,
   output logic             drv_en,
   output logic             ref_diff,
   output logic             ref_on,
   output logic             adc_on,
   output logic             penirq_n,
   output logic             yneg_on
);
   initial begin
      assert (LOW_W >= 1 && LOW_W < RES_W) else $error("touch_adc_seq: bad LOW_W");
      assert (RES_W >= 8 && RES_W <= 27) else $error("touch_adc_seq: bad RES_W");
   end

   logic [2:0] raw_in, sync_q;
   logic       dclk_s, cs_s, din_s, dclk_d;
   logic       tick, abort;
   logic       cmd_done, cmd_track, conv_drv, conv_active;
   tsq_cmd_t   cmd_word;
   logic [1:0] pwr_q;
   logic       ref_q;

   assign raw_in = {cs_n, dclk, din};

   tsq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_q)
   );
   assign {cs_s, dclk_s, din_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dclk_d <= 1'b0;
      else        dclk_d <= dclk_s;
   end
   assign tick  = dclk_s && !dclk_d;
   assign abort = cs_s;

   tsq_cmd_rx #(.RES_W(RES_W), .LOW_W(LOW_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .abort_i(abort), .din_i(din_s),
      .done_o(cmd_done), .word_o(cmd_word), .chan_o(mux_sel), .track_o(cmd_track)
   );

   tsq_out_seq #(.RES_W(RES_W), .LOW_W(LOW_W)) u_out (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .abort_i(abort), .load_i(cmd_done),
      .load_low_i(cmd_word.low_res),
      .load_diff_i(!cmd_word.se_ref && chan_is_touch(cmd_word.chan)),
      .sample_i(conv_sample), .dout_o(dout), .busy_o(busy), .drv_o(conv_drv),
      .active_o(conv_active), .diff_o(ref_diff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q <= 2'b00;
         ref_q <= 1'b0;
      end else if (cmd_done) begin
         pwr_q <= cmd_word.pwr;
         ref_q <= cmd_word.pwr[1];
      end
   end

   assign sh_track = cmd_track;
   assign drv_en   = (cmd_track && chan_is_touch(mux_sel)) || conv_drv;
   assign dout_oe  = !cs_s;
   assign ref_on   = ref_q;
   assign adc_on   = pwr_q[0] || conv_active || cmd_track;
   assign penirq_n = !(pen_touch && !pwr_q[0]);
   assign yneg_on  = (pwr_q == 2'b00) && !conv_active && !cmd_track;

   AST_NO_TRACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(sh_track && busy));                                          // R3
   AST_SE_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ref_diff) |-> !drv_en);                              // R8
endmodule

// File: tb/touch_adc_seq_test.sv
module touch_adc_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dclk = 1'b0, cs_n = 1'b1, din = 1'b0, pen_touch = 1'b1;
   logic [11:0] conv_sample = '0;
   logic        dout, dout_oe, busy, sh_track, drv_en, ref_diff, ref_on, adc_on, penirq_n, yneg_on;
   logic [2:0]  mux_sel;
   int          checks = 0, fails = 0;

   always #4 clk = ~clk;

   touch_adc_seq uut (
      .clk(clk), .rst_n(rst_n), .dclk(dclk), .cs_n(cs_n), .din(din),
      .conv_sample(conv_sample), .pen_touch(pen_touch), .dout(dout), .dout_oe(dout_oe),
      .busy(busy), .mux_sel(mux_sel), .sh_track(sh_track), .drv_en(drv_en),
      .ref_diff(ref_diff), .ref_on(ref_on), .adc_on(adc_on), .penirq_n(penirq_n),
      .yneg_on(yneg_on)
   );

   function automatic logic tch(input logic [2:0] a);
      return (a == 3'b001) || (a == 3'b011) || (a == 3'b100) || (a == 3'b101);
   endfunction
   function automatic logic dif(input logic [6:0] c);
      return !c[2] && tch(c[6:4]);
   endfunction
   function automatic int nbits(input logic [6:0] c);
      return c[3] ? 8 : 12;
   endfunction
   function automatic logic [11:0] res_al(input logic [11:0] v, input logic lo);
      return lo ? {v[11:4], 4'b0000} : v;
   endfunction

   task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic tick(input logic b);
      @(negedge clk);
      din  = b;
      dclk = 1'b1;
      repeat (4) @(negedge clk);
      dclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic cs_set(input logic v);
      @(negedge clk);
      cs_n = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic cmd_phase(input logic [6:0] c, input int lead);
      logic [7:0] bits = {1'b1, c};
      for (int k = 0; k < lead; k++) begin
         tick(1'b0);
         chk("R1 idle zero", {busy, sh_track}, 0);
      end
      for (int j = 0; j < 8; j++) begin
         tick(bits[7-j]);
         chk("R3 track", sh_track, (j >= 3 && j <= 6));
         if (j == 3) begin
            chk("R2 mux_sel", mux_sel, c[6:4]);
            chk("R8 drv track", drv_en, tch(c[6:4]));
         end
         if (j == 7) begin
            chk("R4 busy", busy, 1);
            chk("R7 ref_diff", ref_diff, dif(c));
            chk("R11 ref_on", ref_on, c[1]);
            chk("R8 drv busy", drv_en, dif(c));
         end
      end
   endtask

   task automatic finish_frame(input logic [6:0] c, input logic [11:0] v, input logic junk);
      int n = nbits(c);
      logic [11:0] r = res_al(v, c[3]);
      for (int i = 0; i < n; i++) begin
         tick(junk && (i <= n - 6));
         chk("R5 dout", dout, r[11-i]);
         chk("R4 busy low", busy, 0);
         chk("R8 drv data", drv_en, dif(c));
      end
      for (int p = 0; p < 3; p++) begin
         tick(1'b0);
         chk("R6 pad", dout, 0);
         chk("R8 drv pad", drv_en, (p == 0) && dif(c));
      end
      tick(1'b0);
      chk("R10 adc_on", adc_on, c[0]);
      chk("R10 penirq_n", penirq_n, c[0]);
      chk("R12 yneg_on", yneg_on, (c[1:0] == 2'b00));
      chk("R11 ref_on hold", ref_on, c[1]);
   endtask

   task automatic run_frame(input logic [6:0] c, input logic [11:0] v, input int lead, input logic junk);
      conv_sample = v;
      cmd_phase(c, lead);
      finish_frame(c, v, junk);
   endtask

   task automatic overlap(input logic [6:0] c1, input logic [11:0] v1, input logic [6:0] c2, input logic [11:0] v2);
      int n1 = nbits(c1);
      logic [11:0] r1 = res_al(v1, c1[3]);
      logic [7:0]  nb = {1'b1, c2};
      conv_sample = v1;
      cmd_phase(c1, 0);
      conv_sample = v2;
      for (int i = 0; i < n1 + 3; i++) begin
         tick((i >= n1 - 5) ? nb[7-(i-(n1-5))] : 1'b0);
         if (i < n1)            chk("R9 old data kept", dout, r1[11-i]);
         else if (i < n1 + 2)   chk("R6 old pad", dout, 0);
         else begin
            chk("R9 new busy", busy, 1);
            chk("R9 new mux_sel", mux_sel, c2[6:4]);
         end
      end
      finish_frame(c2, v2, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R14 reset state
      chk("R14 dout_oe", dout_oe, 0);
      chk("R14 busy", busy, 0);
      chk("R14 track", sh_track, 0);
      chk("R14 ref_on", ref_on, 0);
      chk("R14 adc_on", adc_on, 0);
      chk("R14 yneg_on", yneg_on, 1);
      chk("R14 penirq_n", penirq_n, 0);
      chk("R14 mux_sel", mux_sel, 0);
      cs_set(1'b0);
      chk("R13 dout_oe on", dout_oe, 1);

      run_frame({3'b101, 1'b0, 1'b0, 2'b00}, 12'hA5C, 2, 1'b1);
      run_frame({3'b001, 1'b1, 1'b1, 2'b11}, 12'h3C7, 1, 1'b1);
      run_frame({3'b010, 1'b0, 1'b0, 2'b10}, 12'hFFF, 0, 1'b1);
      run_frame({3'b100, 1'b1, 1'b0, 2'b01}, 12'hFFF, 3, 1'b1);
      run_frame({3'b011, 1'b0, 1'b1, 2'b00}, 12'h801, 0, 1'b0);

      overlap({3'b101, 1'b0, 1'b0, 2'b00}, 12'hC35, {3'b001, 1'b1, 1'b0, 2'b01}, 12'h5AF);
      overlap({3'b011, 1'b1, 1'b1, 2'b10}, 12'h9E3, {3'b100, 1'b0, 1'b0, 2'b11}, 12'h6B1);

      // R13 abort during result output
      conv_sample = 12'hFFF;
      cmd_phase({3'b101, 1'b0, 1'b1, 2'b10}, 0);
      tick(1'b0);
      tick(1'b0);
      cs_set(1'b1);
      chk("R13 dout_oe off", dout_oe, 0);
      chk("R13 busy off", busy, 0);
      chk("R13 adc idle", adc_on, 0);
      chk("R13 ref kept", ref_on, 1);
      cs_set(1'b0);
      run_frame({3'b001, 1'b0, 1'b0, 2'b00}, 12'h2D4, 0, 1'b0);

      // R13 abort inside a command byte
      tick(1'b1);
      tick(1'b1);
      tick(1'b0);
      tick(1'b1);
      cs_set(1'b1);
      chk("R13 track cleared", sh_track, 0);
      cs_set(1'b0);
      run_frame({3'b110, 1'b1, 1'b0, 2'b00}, 12'h7E9, 1, 1'b0);

      for (int f = 0; f < 16; f++) begin
         logic [6:0]  c = 7'($urandom);
         logic [11:0] v = 12'($urandom);
         run_frame(c, v, int'($urandom % 3), 1'($urandom));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule